// File: doc/BRIEF.md
# Split Read Request Decomposer

This block sits on the target side of a bridge between two split-transaction buses. It takes one read request from upstream: a start address, a byte count and a relaxed ordering enable. It also takes a programmed commitment limit, given in kilobytes. From these it produces one or more downstream read requests. Each downstream request carries its own address, length, relaxed ordering attribute and a newly generated 5-bit requester tag. The block then counts the completion bytes that come back for each request. When every byte of the original count has arrived, it raises a one-cycle done pulse. Bus signalling and data buffering are handled elsewhere.

The commitment limit selects the mode. A limit of 32 KB or more forwards the request whole, as a single downstream request. Any smaller limit, including values below 4 KB, splits the request into pieces of at most 512 bytes. The pieces are strictly serialized: a new piece is issued only after the previous piece has been fully completed. A disconnect by the originating master does not stop fetching.

The controller has four states. ST_IDLE waits for a request. It moves to ST_ISSUE when it accepts a request (req_valid high and a non-zero byte count). ST_ISSUE presents one downstream request for one cycle and always moves to ST_WAIT. ST_WAIT counts completion bytes. When the outstanding count for the current piece reaches zero, ST_WAIT moves back to ST_ISSUE if bytes remain, or to ST_DONE if none remain. ST_DONE drives the done pulse for one cycle and always returns to ST_IDLE.

Top module: `split_read_decomposer`

## Requirements
- R1: When commit_kb is below 32, every downstream request length is at most 512 bytes. Every piece except the last is exactly 512 bytes, and the last piece carries the remainder (1 to 512).
- R2: When commit_kb is 32 or more, exactly one downstream request is issued, with the original address and byte count.
- R3: The first piece starts at the accepted address. Each later piece starts at the previous piece's address plus the previous piece's length. The piece lengths sum to the original byte count.
- R4: After a piece is issued, dn_valid stays low until completion beats (cpl_valid with cpl_bytes) have delivered that piece's full length. The next piece appears in the cycle after the clock edge that counts the last byte.
- R5: dn_tag is 0 after reset. It increases by one with each issued downstream request and wraps from 31 to 0.
- R6: dn_ro of every downstream request equals the req_ro_en value captured when the request was accepted.
- R7: src_disc, the originating master's disconnect, has no effect: all pieces are still issued and completed.
- R8: done is high for exactly one cycle. That cycle follows the clock edge that counts the final completion byte of the final piece.
- R9: req_ready is high only in ST_IDLE. A req_valid that arrives while the block is busy is ignored, and so is a req_valid with req_bytes equal to 0.
- R10: After reset, req_ready is 1, dn_valid is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Upstream request present |
| req_addr | input | ADDR_W | Upstream start address |
| req_bytes | input | BC_W | Upstream byte count (1..4096) |
| req_ro_en | input | 1 | Relaxed ordering enable |
| commit_kb | input | KB_W | Commitment limit in kilobytes |
| src_disc | input | 1 | Originating master disconnected (no effect) |
| req_ready | output | 1 | Block idle, request can be accepted |
| dn_valid | output | 1 | Downstream request issued this cycle |
| dn_addr | output | ADDR_W | Downstream request address |
| dn_bytes | output | BC_W | Downstream request length |
| dn_tag | output | TAG_W | Requester tag |
| dn_ro | output | 1 | Relaxed ordering attribute |
| cpl_valid | input | 1 | Completion beat present |
| cpl_bytes | input | BC_W | Bytes carried by the completion beat |
| done | output | 1 | Whole original byte count satisfied |

## Verification
The bench sweeps a grid of commitment limits and byte counts. The limits lie below 4 KB, inside the 4 to 32 KB band, and at or above 32 KB. The byte counts are 1, 511, 512, 513, 1024, 1500 and 4096. Together they separate the whole-forward mode from the split mode and expose off-by-one errors at the 512-byte boundary. Each case returns completions either as one beat or as small uneven beats with idle gaps, which shows whether the next piece waits for the exact byte total. Disconnects, requests made while busy, and zero-length requests are mixed in, and the tag is followed across many wraps.

// File: rtl/rdsplit_pkg.sv
package rdsplit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } split_state_e;
endpackage

// File: rtl/rdsplit_tag_gen.sv
module rdsplit_tag_gen #(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [TAG_W-1:0] tag
);
    always_ff @(posedge clk) begin
        if (!rst_n) tag <= '0;
        else if (advance) tag <= tag + 1'b1;
    end

    // R5: tag steps by one (mod 2**TAG_W) after each issued request
    a_r5_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> tag == TAG_W'($past(tag) + 1'b1));
    a_r5_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(tag));
endmodule

// File: rtl/rdsplit_piece_calc.sv
module rdsplit_piece_calc #(
    parameter int BC_W        = 13,
    parameter int PIECE_BYTES = 512
) (
    input  logic            capped,
    input  logic [BC_W-1:0] remain,
    output logic [BC_W-1:0] piece_len
);
    localparam logic [BC_W-1:0] PIECE = BC_W'(PIECE_BYTES);

    always_comb begin
        if (capped && (remain > PIECE)) piece_len = PIECE;
        else                            piece_len = remain;
    end
endmodule

// File: rtl/rdsplit_cpl_counter.sv
module rdsplit_cpl_counter #(
    parameter int BC_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BC_W-1:0] load_len,
    input  logic            count_en,
    input  logic            cpl_valid,
    input  logic [BC_W-1:0] cpl_bytes,
    output logic [BC_W-1:0] outstanding,
    output logic            piece_clear
);
    logic beat;
    assign beat        = count_en && cpl_valid;
    assign piece_clear = beat && (cpl_bytes >= outstanding);

    always_ff @(posedge clk) begin
        if (!rst_n)           outstanding <= '0;
        else if (load)        outstanding <= load_len;
        else if (piece_clear) outstanding <= '0;
        else if (beat)        outstanding <= outstanding - cpl_bytes;
    end

    // R4: a piece is loaded only when nothing of the previous one is outstanding
    a_r4_load_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> outstanding == '0);
    // R4: without a load the outstanding count never grows
    a_r4_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> outstanding <= $past(outstanding));
endmodule

// File: rtl/split_read_decomposer.sv
module split_read_decomposer
    import rdsplit_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BC_W        = 13,
    parameter int KB_W        = 6,
    parameter int TAG_W       = 5,
    parameter int PIECE_BYTES = 512,
    parameter int WHOLE_KB    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BC_W-1:0]   req_bytes,
    input  logic              req_ro_en,
    input  logic [KB_W-1:0]   commit_kb,
    input  logic              src_disc,
    output logic              req_ready,
    output logic              dn_valid,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [BC_W-1:0]   dn_bytes,
    output logic [TAG_W-1:0]  dn_tag,
    output logic              dn_ro,
    input  logic              cpl_valid,
    input  logic [BC_W-1:0]   cpl_bytes,
    output logic              done
);
    localparam logic [KB_W-1:0] WHOLE_LIM = KB_W'(WHOLE_KB);
    localparam logic [BC_W-1:0] PIECE     = BC_W'(PIECE_BYTES);

    split_state_e      state, state_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic [BC_W-1:0]   remain;
    logic              capped;
    logic              ro_q;
    logic [BC_W-1:0]   piece_len;
    logic [BC_W-1:0]   outstanding;
    logic              piece_clear;
    logic              accept;
    logic              issue;
    logic              disc_seen;

    assign accept = (state == ST_IDLE) && req_valid && (req_bytes != '0);
    assign issue  = (state == ST_ISSUE);

    rdsplit_piece_calc #(.BC_W(BC_W), .PIECE_BYTES(PIECE_BYTES)) u_piece (
        .capped    (capped),
        .remain    (remain),
        .piece_len (piece_len)
    );

    rdsplit_tag_gen #(.TAG_W(TAG_W)) u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (issue),
        .tag     (dn_tag)
    );

    rdsplit_cpl_counter #(.BC_W(BC_W)) u_cpl (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (issue),
        .load_len    (piece_len),
        .count_en    (state == ST_WAIT),
        .cpl_valid   (cpl_valid),
        .cpl_bytes   (cpl_bytes),
        .outstanding (outstanding),
        .piece_clear (piece_clear)
    );

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            remain    <= '0;
            capped    <= 1'b0;
            ro_q      <= 1'b0;
            disc_seen <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cur_addr  <= req_addr;
                remain    <= req_bytes;
                capped    <= (commit_kb < WHOLE_LIM);
                ro_q      <= req_ro_en;
                disc_seen <= 1'b0;
            end else begin
                if (issue) begin
                    cur_addr <= cur_addr + ADDR_W'(piece_len);
                    remain   <= remain - piece_len;
                end
                // disconnect is noted only; fetching carries on regardless
                if (src_disc && (state != ST_IDLE)) disc_seen <= 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT:  if (piece_clear) state_nx = (remain == '0) ? ST_DONE : ST_ISSUE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        dn_valid  = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: dn_valid  = 1'b1;
            ST_WAIT:  ;
            ST_DONE:  done      = 1'b1;
            default:  ;
        endcase
        dn_addr  = cur_addr;
        dn_bytes = piece_len;
        dn_ro    = ro_q;
    end

    // R1: capped mode never emits a piece above the cap
    a_r1_piece_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && capped) |-> (dn_bytes <= PIECE && dn_bytes != '0));
    // R4: a new piece follows only the clearing of the previous one
    a_r4_issue_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !$past(accept)) |-> $past(piece_clear));
    // R8: done lasts one cycle and follows the final clearing edge
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(piece_clear));
    // R9: busy block does not report ready
    a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!dn_valid && !done));
    // R7: a disconnect does not return the block to idle early
    a_r7_disc_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_seen && state == ST_WAIT && !piece_clear) |=> state == ST_WAIT);
endmodule

// File: tb/split_read_decomposer_bench.sv
module split_read_decomposer_bench;
    localparam int ADDR_W = 32;
    localparam int BC_W   = 13;
    localparam int KB_W   = 6;
    localparam int TAG_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [BC_W-1:0]   req_bytes = '0;
    logic              req_ro_en = 1'b0;
    logic [KB_W-1:0]   commit_kb = '0;
    logic              src_disc = 1'b0;
    logic              req_ready, dn_valid, dn_ro, done;
    logic [ADDR_W-1:0] dn_addr;
    logic [BC_W-1:0]   dn_bytes;
    logic [TAG_W-1:0]  dn_tag;
    logic              cpl_valid = 1'b0;
    logic [BC_W-1:0]   cpl_bytes = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_tag = 0;

    always #2.5 clk = ~clk;

    split_read_decomposer u_split_read_decomposer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_bytes(req_bytes), .req_ro_en(req_ro_en), .commit_kb(commit_kb),
        .src_disc(src_disc), .req_ready(req_ready), .dn_valid(dn_valid),
        .dn_addr(dn_addr), .dn_bytes(dn_bytes), .dn_tag(dn_tag), .dn_ro(dn_ro),
        .cpl_valid(cpl_valid), .cpl_bytes(cpl_bytes), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int addr, input int bytes, input int kb,
                            input bit ro, input int beat);
        int  rem   = bytes;
        int  a     = addr;
        bit  cap   = (kb < 32);
        int  npc   = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready idle", req_ready, 1);
        req_valid = 1'b1; req_addr = addr; req_bytes = bytes[BC_W-1:0];
        req_ro_en = ro;   commit_kb = kb[KB_W-1:0];
        @(negedge clk);
        req_valid = 1'b0;
        while (rem > 0) begin
            int len = (cap && rem > 512) ? 512 : rem;
            int out;
            chk(dn_valid == 1'b1, "R4 piece issued", dn_valid, 1);
            chk(dn_addr == a[ADDR_W-1:0], "R3 address", dn_addr, a);
            chk(dn_bytes == len[BC_W-1:0], cap ? "R1 length" : "R2 length", dn_bytes, len);
            chk(dn_tag == exp_tag[TAG_W-1:0], "R5 tag", dn_tag, exp_tag);
            chk(dn_ro == ro, "R6 relaxed ordering", dn_ro, ro);
            chk(req_ready == 1'b0, "R9 busy", req_ready, 0);
            exp_tag = (exp_tag + 1) % 32;
            a += len; rem -= len; npc++;
            out = len;
            @(negedge clk);
            // request while busy must be ignored
            req_valid = 1'b1; req_addr = 32'hDEAD_0000; req_bytes = 13'd7; commit_kb = 6'd50;
            while (out > 0) begin
                int b = (beat < out) ? beat : out;
                chk(dn_valid == 1'b0, "R4 wait quiet", dn_valid, 0);
                chk(done == 1'b0, "R8 no early done", done, 0);
                cpl_valid = 1'b1; cpl_bytes = b[BC_W-1:0];
                src_disc  = (out % 3 == 0);
                @(negedge clk);
                req_valid = 1'b0;
                out -= b;
                cpl_valid = 1'b0;
                if (out > 0 && beat < 512) begin
                    chk(dn_valid == 1'b0, "R4 gap quiet", dn_valid, 0);
                    @(negedge clk);
                end
            end
            src_disc = 1'b0;
        end
        chk(!cap ? (npc == 1) : (npc == (bytes + 511) / 512), cap ? "R1 piece count" : "R2 single",
            npc, cap ? (bytes + 511) / 512 : 1);
        chk(dn_valid == 1'b0, "R3 no extra piece", dn_valid, 0);
        chk(done == 1'b1, "R8 done", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        chk(req_ready == 1'b1, "R9 back to idle", req_ready, 1);
    endtask

    initial begin
        int kbs[8]   = '{0, 3, 4, 16, 31, 32, 40, 63};
        int sizes[7] = '{1, 511, 512, 513, 1024, 1500, 4096};
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(req_ready == 1'b1, "R10 ready", req_ready, 1);
        chk(dn_valid == 1'b0, "R10 dn_valid", dn_valid, 0);
        chk(done == 1'b0, "R10 done", done, 0);
        chk(dn_tag == 0, "R5 reset tag", dn_tag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: zero-length request ignored
        req_valid = 1'b1; req_bytes = '0; req_addr = 32'h100;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b1, "R9 zero ignored", req_ready, 1);
        chk(dn_valid == 1'b0, "R9 zero no issue", dn_valid, 0);
        for (int k = 0; k < 8; k++) begin
            for (int s = 0; s < 7; s++) begin
                for (int m = 0; m < 2; m++) begin
                    run_case(32'h1000_0000 + k * 32'h0001_0000 + s * 36 + m * 4,
                             sizes[s], kbs[k], ((k + s + m) % 2) == 1,
                             (m == 0) ? 4096 : 200 - s * 17);
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule